// File: doc/BRIEF.md
# Banked Synchronous Single-Port RAM

This block is a single-port synchronous RAM assembled from many small sub-banks of equal size. The top bits of the word address pick one sub-bank and the low bits address a word inside it. On any access, only that one sub-bank has its enable raised, so the idle banks draw no access power. A read registers the address, and the data appears at the output one clock later. The `OUT_REG` parameter can add a second register to the output path. That register costs one more cycle of latency and shortens the path to the next stage.

The output of the sub-banks is collected by a two-level selection tree whose shape is set by `GROUP_SIZE`:

- **Chain within a group.** The banks of each group feed a priority chain of 2:1 selectors.
- **Group multiplexer.** A small multiplexer then chooses among the group outputs.

The two extreme settings work out as follows:

- **`GROUP_SIZE` = 1** gives one wide multiplexer over all banks.
- **`GROUP_SIZE` = `NUM_BANKS`** gives a single chain and no group multiplexer.

The values in between form hybrids. For example, groups of four with the full 32-bank count give eight chains and an 8:1 multiplexer. The bank-select field is registered together with the read, so the selection tree always uses the select that belongs to the data being returned. A `GROUP_SIZE` that is not a power of two dividing `NUM_BANKS` stops elaboration. The full-size configuration is 32 banks of 1K words (`BANK_AW` = 10), 32 bits wide, with a 15-bit address. The defaults are kept smaller so that a plain elaboration stays light.

Top module: `banked_ram`

## Requirements
- R1: Each of the NUM_BANKS * 2^BANK_AW word locations stores its own DATA_W-bit value. The bank is addr[ADDR_W-1:BANK_AW] and the word within the bank is addr[BANK_AW-1:0], so a write to one address changes no other address.
- R2: While `en` is high, exactly one sub-bank enable is active, and it is the one named by the upper address field. While `en` is low, no sub-bank enable is active.
- R3: Data read with `en`=1 at clock edge k appears on `rdata` after edge k when OUT_REG=0, and after edge k+1 when OUT_REG=1.
- R4: While no access is made, `rdata` keeps the value of the most recent access.
- R5: An access with `en`=1 and `we`=1 stores `wdata` and returns the previous contents of that address on `rdata` (read-first).
- R6: With `en`=0, `we` and `wdata` have no effect: no location is written.
- R7: GROUP_SIZE = 1, GROUP_SIZE = 4 and GROUP_SIZE = NUM_BANKS give identical `rdata` for the same stimulus and OUT_REG setting.
- R8: With OUT_REG=1, `rdata` is 0 after reset until the first access returns data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Access enable for this cycle |
| we | input | 1 | Write when `en` is high |
| addr | input | ADDR_W | Word address: upper SEL_W bits select the bank, lower BANK_AW bits the word |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data; on a write, the old contents of the address |

## Verification
These faults can occur inside the block:

- **Stale or mismatched bank-select register.** The selection tree returns the word from the wrong bank. This shows on `rdata` in the first checked cycle after an access that crosses banks.
- **Wrong bank or word decode.** Data is stored at an aliased location. This is found by the read-back sweep, at the first read of a location that was overwritten.
- **Lost read-first ordering, or a write leaking through while disabled.** This shows on the very next read of the affected address.
- **Extra or missing output register.** This shifts every returned word by one cycle, so the first read after reset already miscompares.

// File: rtl/banked_ram_pkg.sv
package banked_ram_pkg;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic bit group_ok(input int unsigned grp, input int unsigned banks);
    return is_pow2(grp) && is_pow2(banks) && (grp <= banks) && ((banks % grp) == 0);
  endfunction

endpackage

// File: rtl/ram_bank.sv
module ram_bank #(
  parameter int DATA_W = 32,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-first: the read register samples the old word in the write cycle.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/ram_cascade_mux.sv
module ram_cascade_mux #(
  parameter int DATA_W = 32,
  parameter int G      = 4,
  localparam int LSW   = $clog2(G)
) (
  input  logic [LSW-1:0]         sel,
  input  logic [G-1:0][DATA_W-1:0] rd_in,
  output logic [DATA_W-1:0]      rd_out
);
  logic [G-1:0][DATA_W-1:0] chain;

  assign chain[0] = rd_in[0];

  for (genvar k = 1; k < G; k++) begin : g_link
    assign chain[k] = (sel == LSW'(k)) ? rd_in[k] : chain[k-1];
  end

  assign rd_out = chain[G-1];
endmodule

// File: rtl/banked_ram.sv
module banked_ram
  import banked_ram_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BANK_AW    = 5,
  parameter int NUM_BANKS  = 32,
  parameter int GROUP_SIZE = 4,
  parameter bit OUT_REG    = 1'b0,
  localparam int SEL_W     = $clog2(NUM_BANKS),
  localparam int ADDR_W    = SEL_W + BANK_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int NUM_GROUPS = NUM_BANKS / GROUP_SIZE;
  localparam int GSW        = $clog2(NUM_GROUPS);
  localparam int LSW        = $clog2(GROUP_SIZE);

  if (!group_ok(GROUP_SIZE, NUM_BANKS)) begin : g_bad_group
    $error("GROUP_SIZE must be a power of two dividing NUM_BANKS");
  end

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  // Address split and bank enables.
  logic [SEL_W-1:0]   bank_idx;
  logic [BANK_AW-1:0] word_idx;
  logic [NUM_BANKS-1:0] bank_en;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd;

  assign bank_idx = addr[ADDR_W-1 -: SEL_W];
  assign word_idx = addr[BANK_AW-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_en[b] = en && (bank_idx == SEL_W'(b));
    ram_bank #(.DATA_W(DATA_W), .AW(BANK_AW)) u_bank (
      .clk   (clk),
      .en    (bank_en[b]),
      .we    (we),
      .addr  (word_idx),
      .wdata (wdata),
      .rdata (bank_rd[b])
    );
  end

  // Bank select travels with the read.
  logic [SEL_W-1:0] sel_d, sel_q;
  always_comb begin
    sel_d = sel_q;
    if (en) sel_d = bank_idx;
  end
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) sel_q <= '0;
    else           sel_q <= sel_d;
  end

  // Selection tree: chains inside groups, then a group multiplexer.
  logic [NUM_GROUPS-1:0][DATA_W-1:0] grp_out;
  logic [DATA_W-1:0] rdata_c;

  if (GROUP_SIZE == 1) begin : g_flat
    assign grp_out = bank_rd;
  end else begin : g_chains
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      ram_cascade_mux #(.DATA_W(DATA_W), .G(GROUP_SIZE)) u_chain (
        .sel    (sel_q[LSW-1:0]),
        .rd_in  (bank_rd[g*GROUP_SIZE +: GROUP_SIZE]),
        .rd_out (grp_out[g])
      );
    end
  end

  if (NUM_GROUPS == 1) begin : g_no_gmux
    assign rdata_c = grp_out[0];
  end else begin : g_gmux
    assign rdata_c = grp_out[sel_q[SEL_W-1 -: GSW]];
  end

  // Optional output register.
  if (OUT_REG) begin : g_oreg
    logic en_q;
    logic [DATA_W-1:0] out_d, out_q;
    always_comb begin
      out_d = out_q;
      if (en_q) out_d = rdata_c;
    end
    always_ff @(posedge clk or negedge rst_sync) begin
      if (!rst_sync) begin
        en_q  <= 1'b0;
        out_q <= '0;
      end else begin
        en_q  <= en;
        out_q <= out_d;
      end
    end
    assign rdata = out_q;
  end else begin : g_comb
    assign rdata = rdata_c;
  end
endmodule

// File: rtl/banked_ram_chk.sv
module banked_ram_chk #(
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 32,
  parameter int SEL_W     = 5,
  parameter bit OUT_REG   = 1'b0
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             en,
  input logic [NUM_BANKS-1:0]             bank_en,
  input logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd,
  input logic [SEL_W-1:0]                 sel_q,
  input logic [DATA_W-1:0]                rdata
);
  logic en_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_d <= 1'b0;
    else        en_d <= en;
  end

  // R2: one bank enabled per access
  a_r2_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $countones(bank_en) == 1);

  // R2: no bank enabled when idle
  a_r2_no_bank_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> bank_en == '0);

  // R6: idle cycles leave every bank read register untouched
  a_r6_idle_banks: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(bank_rd));

  // R4: output holds with no access in flight
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !en_d) |=> $stable(rdata));

  if (OUT_REG) begin : g_lat2
    // R3: output register returns the selected bank one cycle later
    a_r3_mux_path: assert property (@(posedge clk) disable iff (!rst_n)
      en_d |=> rdata == $past(bank_rd[sel_q]));
  end else begin : g_lat1
    // R3: output follows the selected bank directly
    a_r3_mux_path: assert property (@(posedge clk) disable iff (!rst_n)
      en_d |-> rdata == bank_rd[sel_q]);
  end
endmodule

bind banked_ram banked_ram_chk #(
  .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst_n(rst_sync), .en(en), .bank_en(bank_en),
  .bank_rd(bank_rd), .sel_q(sel_q), .rdata(rdata)
);

// File: tb/tb_banked_ram.sv
`timescale 1ns/1ps
module tb_banked_ram;
  localparam int DW  = 32;
  localparam int BAW = 3;
  localparam int NB  = 32;
  localparam int AW  = 5 + BAW;
  localparam int NW  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic en, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wd;
  logic [DW-1:0] rd_a, rd_p, rd_c;

  always #2.5 clk = ~clk;

  // Hybrid groups of 4, no output register.
  banked_ram #(.DATA_W(DW), .BANK_AW(BAW), .NUM_BANKS(NB), .GROUP_SIZE(4), .OUT_REG(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .addr(addr), .wdata(wd), .rdata(rd_a));
  // Fully parallel multiplexer.
  banked_ram #(.DATA_W(DW), .BANK_AW(BAW), .NUM_BANKS(NB), .GROUP_SIZE(1), .OUT_REG(1'b0)) dut_par (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .addr(addr), .wdata(wd), .rdata(rd_p));
  // Single chain with output register.
  banked_ram #(.DATA_W(DW), .BANK_AW(BAW), .NUM_BANKS(NB), .GROUP_SIZE(NB), .OUT_REG(1'b1)) dut_chain (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .addr(addr), .wdata(wd), .rdata(rd_c));

  int vectors = 0;
  int miscompares = 0;
  string tag = "R1";

  logic [DW-1:0] mdl [NW];
  bit            kn  [NW];
  logic [DW-1:0] e1, e2;
  bit            v1, v2;

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return (32'(a) * 32'h9E3779B1) ^ (32'(s) * 32'h01010101) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string t);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: rdata %h expected %h at %0t", t, got, exp, $time);
    end
  endtask

  // One cycle: check outputs due now, update expectations, drive next inputs.
  task automatic step(input bit ien, input bit iwe, input int ia, input logic [DW-1:0] iwd);
    @(negedge clk);
    if (v1) begin
      chk(rd_a, e1, tag);
      chk(rd_p, e1, "R7");
    end
    if (v2) chk(rd_c, e2, tag == "R1" ? "R3" : tag);
    e2 = e1; v2 = v1;
    if (ien) begin
      v1 = kn[ia];
      e1 = mdl[ia];
      if (iwe) begin
        mdl[ia] = iwd;
        kn[ia]  = 1'b1;
      end
    end
    en = ien; we = iwe; addr = AW'(ia); wd = iwd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, '0);
  endtask

  bit done = 1'b0;

  initial begin
    for (int i = 0; i < NW; i++) kn[i] = 1'b0;
    v1 = 0; v2 = 0; e1 = '0; e2 = '0;
    rst_n = 1'b0; en = 0; we = 0; addr = '0; wd = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8: output register cleared by reset
    chk(rd_c, '0, "R8");

    // R1: fill every location
    for (int a = 0; a < NW; a++) step(1'b1, 1'b1, a, pat(a, 1));
    idle(2);
    // R1, R3: ascending read-back
    tag = "R1";
    for (int a = 0; a < NW; a++) step(1'b1, 1'b0, a, '0);
    idle(3);
    // R4: descending reads with idle gaps, holds checked in the gaps
    tag = "R4";
    for (int a = NW - 1; a >= 0; a--) begin
      step(1'b1, 1'b0, a, '0);
      if (a % 3 == 0) idle(2);
    end
    idle(3);
    // R5: write returns old contents, then new contents on read
    tag = "R5";
    for (int a = 0; a < NW; a += 7) begin
      step(1'b1, 1'b1, a, pat(a, 2));
      step(1'b1, 1'b0, a, '0);
    end
    idle(3);
    // R6: disabled writes must not land
    tag = "R6";
    for (int a = 0; a < NW; a += 5) step(1'b0, 1'b1, a, ~pat(a, 9));
    for (int a = 0; a < NW; a += 5) step(1'b1, 1'b0, a, '0);
    idle(3);
    // R2: alternate between distant banks, each bank keeps its own data
    tag = "R2";
    for (int a = 0; a < NW / 2; a++) begin
      step(1'b1, 1'b0, a, '0);
      step(1'b1, 1'b0, NW - 1 - a, '0);
    end
    idle(3);
    // R7: mixed pseudo-random traffic across all three configurations
    tag = "R7";
    begin
      int unsigned s = 32'h1234_5678;
      for (int i = 0; i < 1500; i++) begin
        s = s * 32'd1664525 + 32'd1013904223;
        step(s[31:30] != 2'b00, s[29], int'(s[AW+7:8]), pat(i, 3));
      end
    end
    idle(4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule